// File: doc/BRIEF.md
# Four-Channel Pulse-Width Modulator with Deferred Update

The block drives four pulse-width modulated pins from one clock. Each channel has a free-running up-counter that is clocked through a power-of-two prescaler. The counter wraps after a programmable period. The pin level comes from comparing the counter against a programmable duty threshold, and a per-channel polarity bit can invert it. Software controls the block through a small synchronous register bus. Read data comes back one cycle after the read strobe.

Channels are switched on by writing ones to a set register and switched off by writing ones to a separate clear register, so no read-modify-write is needed. A disabled channel accepts its duty and period values directly. A running channel takes new values only through a per-channel holding register. The holding register is aimed at duty or period by a mode bit, and its content is copied over only at the clock where the counter wraps. A running waveform therefore never shows a partly-changed period.

Top module: `pwmc_top`

## Requirements
- R1: A write to address 0x004 sets the enable of each channel n whose data bit n is 1. A write to 0x008 clears the enable of each such channel. Data bits that are 0 leave the matching channel unchanged.
- R2: Address 0x00C reads the enable state of channel n in bit n (bits 3:0), and all higher bits read as zero.
- R3: Channel n occupies the window 0x200 + n*0x20. Within that window: mode at +0x00, duty at +0x04, period at +0x08, holding register at +0x10. The mode word reads back only bits 3:0 (prescale), 9 (invert) and 10 (holding target); every other bit reads as zero.
- R4: With prescale field k, the channel counter advances once every 2^k clocks. Field values above 10 behave as 10.
- R5: The counter runs 0..P-1 and then wraps, where P is the period. With invert = 0, the pin is low while counter < duty and high otherwise, so duty >= P keeps it low for the whole period. With invert = 1, the pin is the complement.
- R6: A disabled channel holds its pin at the invert bit's value and its counter at 0. After enable, counting restarts from 0, so the first clock after enabling shows the level for counter 0.
- R7: Duty and period store only bits 15:0 of the written data. Bits 31:16 read as zero.
- R8: Direct writes to duty or period take effect while the channel is disabled and are ignored while it is enabled.
- R9: A write to the holding register keeps the value pending. Mode bit 10, as it stands at the time of the write, selects the target: 0 for duty, 1 for period. The value is copied into the target on the clock where the counter wraps, so a readback before the wrap still shows the old value.
- R10: Reads of the enable-set, enable-clear and holding registers return zero.
- R11: Read data appears on the clock after the read strobe. Unmapped addresses read as zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe for one cycle |
| bus_rd | input | 1 | Read strobe for one cycle |
| bus_addr | input | 12 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered |
| pwm_out | output | 4 | Modulated pins, bit n for channel n |

## Verification
The hardest case to reach is a holding-register commit on a running channel, because the bench must observe the pending value before the wrap and the committed value after it. The stimulus makes this deterministic. It first disables and re-enables the channel, which restarts the counter at a known clock. It then uses a long prescaled period, so the holding write and the first readback both land well before the wrap. A wait longer than one period then guarantees the commit has happened. The duty-cycle measurement uses a window exactly one period long, so the result does not depend on the phase of the counter.

// File: rtl/pwmc_pkg.sv
package pwmc_pkg;

    localparam int AW        = 12;
    localparam int DW        = 32;
    localparam int CW        = 16;
    localparam int PW        = 4;
    localparam int MAXP      = 10;
    localparam int WIN_LSB   = 5;
    localparam int WBASE_LSB = 9;
    localparam int WIDX_W    = WBASE_LSB - WIN_LSB;
    localparam int WTAG_W    = AW - WBASE_LSB;

    localparam logic [AW-1:0] A_SET  = 12'h004;
    localparam logic [AW-1:0] A_CLR  = 12'h008;
    localparam logic [AW-1:0] A_STAT = 12'h00C;

    localparam logic [WIN_LSB-1:0] O_MODE = 5'h00;
    localparam logic [WIN_LSB-1:0] O_DUTY = 5'h04;
    localparam logic [WIN_LSB-1:0] O_PRD  = 5'h08;
    localparam logic [WIN_LSB-1:0] O_HOLD = 5'h10;

    typedef struct packed {
        logic          hold_to_prd;
        logic          invert;
        logic [PW-1:0] pres;
    } mode_t;

    function automatic mode_t word_to_mode(logic [DW-1:0] w);
        mode_t m;
        m.hold_to_prd = w[10];
        m.invert      = w[9];
        m.pres        = w[PW-1:0];
        return m;
    endfunction

    function automatic logic [DW-1:0] mode_to_word(mode_t m);
        logic [DW-1:0] w;
        w           = '0;
        w[10]       = m.hold_to_prd;
        w[9]        = m.invert;
        w[PW-1:0]   = m.pres;
        return w;
    endfunction

endpackage

// File: rtl/pwmc_prescaler.sv
module pwmc_prescaler
    import pwmc_pkg::*;
#(
    parameter int MAXSH = MAXP
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          run,
    input  logic [PW-1:0] sel,
    output logic          tick
);
    logic [MAXSH-1:0] div_q;
    logic [PW-1:0]    shift;
    logic [MAXSH-1:0] mask;

    // saturate out-of-range prescale codes
    assign shift = (sel > PW'(MAXSH)) ? PW'(MAXSH) : sel;
    assign mask  = ~({MAXSH{1'b1}} << shift);
    assign tick  = run && ((div_q & mask) == mask);

    always_ff @(posedge clk) begin
        if (rst || !run) div_q <= '0;
        else             div_q <= div_q + 1'b1;
    end
endmodule

// File: rtl/pwmc_channel.sv
module pwmc_channel
    import pwmc_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          en,
    input  mode_t         mode,
    input  logic          wr_duty,
    input  logic          wr_prd,
    input  logic          wr_hold,
    input  logic [CW-1:0] wval,
    output logic [CW-1:0] duty,
    output logic [CW-1:0] prd,
    output logic [CW-1:0] cnt,
    output logic          wrap,
    output logic          pin
);
    logic          tick;
    logic          pend_q;
    logic          pend_prd_q;
    logic [CW-1:0] pend_val_q;

    pwmc_prescaler #(.MAXSH(MAXP)) u_pre (
        .clk (clk),
        .rst (rst),
        .run (en),
        .sel (mode.pres),
        .tick(tick)
    );

    assign wrap = en && tick && (({1'b0, cnt} + 1'b1) >= {1'b0, prd});
    assign pin  = en ? ((cnt >= duty) ^ mode.invert) : mode.invert;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt        <= '0;
            duty       <= '0;
            prd        <= '0;
            pend_q     <= 1'b0;
            pend_prd_q <= 1'b0;
            pend_val_q <= '0;
        end else begin
            if (!en) begin
                cnt <= '0;
                if (wr_duty) duty <= wval;
                if (wr_prd)  prd  <= wval;
            end else if (wrap) begin
                cnt <= '0;
                if (pend_q) begin
                    if (pend_prd_q) prd  <= pend_val_q;
                    else            duty <= pend_val_q;
                    pend_q <= 1'b0;
                end
            end else if (tick) begin
                cnt <= cnt + 1'b1;
            end
            // a fresh holding write wins over a commit in the same clock
            if (wr_hold) begin
                pend_q     <= 1'b1;
                pend_prd_q <= mode.hold_to_prd;
                pend_val_q <= wval;
            end
        end
    end
endmodule

// File: rtl/pwmc_top.sv
module pwmc_top
    import pwmc_pkg::*;
#(
    parameter int NCH = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          bus_wr,
    input  logic          bus_rd,
    input  logic [AW-1:0] bus_addr,
    input  logic [DW-1:0] bus_wdata,
    output logic [DW-1:0] bus_rdata,
    output logic [NCH-1:0] pwm_out
);
    logic [NCH-1:0]          en_q;
    logic [NCH-1:0][CW-1:0]  duty_a;
    logic [NCH-1:0][CW-1:0]  prd_a;
    logic [NCH-1:0][CW-1:0]  cnt_a;
    logic [NCH-1:0][DW-1:0]  mode_w;
    logic [NCH-1:0]          wrap_a;
    logic [DW-1:0]           rd_mux;

    logic                    in_win;
    logic [WIDX_W-1:0]       win_idx;
    logic [WIN_LSB-1:0]      off;
    logic                    wr_set;
    logic                    wr_clr;

    assign in_win  = bus_addr[AW-1:WBASE_LSB] == WTAG_W'(1);
    assign win_idx = bus_addr[WBASE_LSB-1:WIN_LSB];
    assign off     = bus_addr[WIN_LSB-1:0];
    assign wr_set  = bus_wr && (bus_addr == A_SET);
    assign wr_clr  = bus_wr && (bus_addr == A_CLR);

    always_ff @(posedge clk) begin
        if (rst)         en_q <= '0;
        else if (wr_set) en_q <= en_q | bus_wdata[NCH-1:0];
        else if (wr_clr) en_q <= en_q & ~bus_wdata[NCH-1:0];
    end

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        logic  hit;
        mode_t mode_q;

        assign hit = bus_wr && in_win && (win_idx == WIDX_W'(g));

        always_ff @(posedge clk) begin
            if (rst)                        mode_q <= '0;
            else if (hit && off == O_MODE)  mode_q <= word_to_mode(bus_wdata);
        end

        assign mode_w[g] = mode_to_word(mode_q);

        pwmc_channel u_ch (
            .clk    (clk),
            .rst    (rst),
            .en     (en_q[g]),
            .mode   (mode_q),
            .wr_duty(hit && off == O_DUTY),
            .wr_prd (hit && off == O_PRD),
            .wr_hold(hit && off == O_HOLD),
            .wval   (bus_wdata[CW-1:0]),
            .duty   (duty_a[g]),
            .prd    (prd_a[g]),
            .cnt    (cnt_a[g]),
            .wrap   (wrap_a[g]),
            .pin    (pwm_out[g])
        );
    end

    always_comb begin
        rd_mux = '0;
        if (bus_addr == A_STAT) rd_mux[NCH-1:0] = en_q;
        for (int n = 0; n < NCH; n++) begin
            if (in_win && win_idx == WIDX_W'(n)) begin
                case (off)
                    O_MODE:  rd_mux = mode_w[n];
                    O_DUTY:  rd_mux = {{(DW-CW){1'b0}}, duty_a[n]};
                    O_PRD:   rd_mux = {{(DW-CW){1'b0}}, prd_a[n]};
                    default: rd_mux = '0;
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst)         bus_rdata <= '0;
        else if (bus_rd) bus_rdata <= rd_mux;
    end
endmodule

// File: rtl/pwmc_chk.sv
module pwmc_chk
    import pwmc_pkg::*;
#(
    parameter int NCH = 4
) (
    input logic                   clk,
    input logic                   rst,
    input logic                   bus_wr,
    input logic                   bus_rd,
    input logic [AW-1:0]          bus_addr,
    input logic [DW-1:0]          bus_wdata,
    input logic [DW-1:0]          bus_rdata,
    input logic [NCH-1:0]         en_q,
    input logic [NCH-1:0]         wrap_a,
    input logic [NCH-1:0][CW-1:0] cnt_a,
    input logic [NCH-1:0][CW-1:0] prd_a,
    input logic [NCH-1:0][CW-1:0] duty_a
);
    for (genvar g = 0; g < NCH; g++) begin : g_p
        p_set_r1: assert property (@(posedge clk) disable iff (rst)
            (bus_wr && bus_addr == A_SET && bus_wdata[g]) |=> en_q[g]);

        p_clr_r1: assert property (@(posedge clk) disable iff (rst)
            (bus_wr && bus_addr == A_CLR && bus_wdata[g]) |=> !en_q[g]);

        p_cnt_range_r5: assert property (@(posedge clk) disable iff (rst)
            (en_q[g] && prd_a[g] != '0) |-> (cnt_a[g] < prd_a[g]));

        p_idle_cnt_r6: assert property (@(posedge clk) disable iff (rst)
            !en_q[g] |=> (cnt_a[g] == '0));

        p_duty_hold_r9: assert property (@(posedge clk) disable iff (rst)
            (en_q[g] && !wrap_a[g]) |=> $stable(duty_a[g]));
    end

    p_wo_zero_r10: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && (bus_addr == A_SET || bus_addr == A_CLR)) |=> (bus_rdata == '0));
endmodule

bind pwmc_top pwmc_chk #(.NCH(NCH)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .bus_wr   (bus_wr),
    .bus_rd   (bus_rd),
    .bus_addr (bus_addr),
    .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata),
    .en_q     (en_q),
    .wrap_a   (wrap_a),
    .cnt_a    (cnt_a),
    .prd_a    (prd_a),
    .duty_a   (duty_a)
);

// File: tb/pwmc_top_tb.sv
module pwmc_top_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [3:0]  pwm_out;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;
    bit polv [4];

    always #10 clk = ~clk;

    pwmc_top u_dut (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .pwm_out(pwm_out)
    );

    function automatic logic [11:0] chA(int ch, int off);
        return 12'(32'h200 + ch * 32'h20 + off);
    endfunction

    // high clocks in one full period window
    function automatic int exp_high(int p, int d, int k, bit inv);
        int per = (p == 0 ? 1 : p) << k;
        int hi  = ((d >= p) ? 0 : (p - d)) << k;
        return inv ? per - hi : hi;
    endfunction

    task automatic chk(string req, longint got, longint exp);
        n_chk++;
        if (got != exp) begin
            n_bad++;
            $display("FAIL %s: got %0h expected %0h", req, got, exp);
        end
    endtask

    task automatic wr(logic [11:0] a, logic [31:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(logic [11:0] a, output logic [31:0] d);
        bus_addr = a; bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0;
        d = bus_rdata;
    endtask

    task automatic measure(int ch, int len, output int hi);
        hi = int'(pwm_out[ch]);
        for (int i = 1; i < len; i++) begin
            @(negedge clk);
            hi += int'(pwm_out[ch]);
        end
    endtask

    initial begin
        logic [31:0] d;
        int hi;
        int seed;
        seed = int'($urandom(32'd7321));
        for (int i = 0; i < 4; i++) polv[i] = 1'b0;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        chk("R6 reset pins", pwm_out, 0);
        rd(12'h00C, d); chk("R2 reset status", d, 0);

        // R1 / R2 set-clear registers
        wr(12'h004, 32'hFFFF_FFFF);
        rd(12'h00C, d); chk("R2 status all on, upper zero", d, 32'hF);
        wr(12'h008, 32'h2);
        rd(12'h00C, d); chk("R1 clear one channel only", d, 32'hD);
        wr(12'h004, 32'h0);
        rd(12'h00C, d); chk("R1 zero set bits no effect", d, 32'hD);
        wr(12'h008, 32'hF);
        rd(12'h00C, d); chk("R1 clear all", d, 0);

        // R3 / R7 / R10 / R11 register map
        wr(chA(1, 0), 32'hFFFF_FFFF);
        rd(chA(1, 0), d); chk("R3 mode readback mask", d, 32'h60F);
        wr(chA(1, 0), 32'h0);
        wr(chA(2, 4), 32'h0001_2345);
        rd(chA(2, 4), d); chk("R7 duty 16-bit", d, 32'h2345);
        wr(chA(3, 8), 32'hABCD_0042);
        rd(chA(3, 8), d); chk("R7 period 16-bit", d, 32'h42);
        rd(12'h004, d);   chk("R10 set reg reads zero", d, 0);
        rd(12'h008, d);   chk("R10 clear reg reads zero", d, 0);
        rd(chA(2, 16), d); chk("R10 holding reg reads zero", d, 0);
        rd(12'h100, d);   chk("R11 unmapped reads zero", d, 0);
        rd(chA(2, 12), d); chk("R11 unmapped window slot zero", d, 0);

        // R4 largest prescale and saturation of larger codes
        wr(chA(0, 4), 1); wr(chA(0, 8), 2); wr(chA(0, 0), 10);
        wr(12'h004, 1);
        measure(0, 2048, hi); chk("R4 prescale 10", hi, 1024);
        wr(12'h008, 1);
        wr(chA(0, 0), 15);
        wr(12'h004, 1);
        measure(0, 2048, hi); chk("R4 prescale code 15 acts as 10", hi, 1024);
        wr(12'h008, 1);

        // R9 deferred duty update, R8 ignored direct write
        wr(chA(0, 0), 3); wr(chA(0, 4), 3); wr(chA(0, 8), 10);
        wr(12'h004, 1);
        wr(chA(0, 16), 7);
        rd(chA(0, 4), d); chk("R9 duty pending before wrap", d, 3);
        repeat (100) @(negedge clk);
        rd(chA(0, 4), d); chk("R9 duty committed after wrap", d, 7);
        wr(chA(0, 4), 5);
        rd(chA(0, 4), d); chk("R8 direct duty ignored while on", d, 7);
        wr(chA(0, 8), 30);
        rd(chA(0, 8), d); chk("R8 direct period ignored while on", d, 10);
        measure(0, 80, hi); chk("R9 waveform with new duty", hi, 24);

        // R9 deferred period update
        wr(12'h008, 1);
        wr(chA(0, 0), 32'h403);
        wr(12'h004, 1);
        wr(chA(0, 16), 20);
        rd(chA(0, 8), d); chk("R9 period pending before wrap", d, 10);
        repeat (200) @(negedge clk);
        rd(chA(0, 8), d); chk("R9 period committed", d, 20);
        measure(0, 160, hi); chk("R9 waveform with new period", hi, 104);
        wr(12'h008, 1);
        wr(chA(0, 0), 0);
        chk("R6 disabled pin idle", pwm_out[0], 0);

        // R5 / R6 / R8 random waveforms
        for (int it = 0; it < 30; it++) begin
            int ch  = int'($urandom_range(3, 0));
            int k   = int'($urandom_range(3, 0));
            int p   = int'($urandom_range(24, 1));
            int du  = int'($urandom_range(p + 2, 0));
            bit inv = 1'($urandom_range(1, 0));
            wr(12'h008, 32'hF);
            polv[ch] = inv;
            wr(chA(ch, 0), {22'b0, inv, 5'b0, 4'(k)});
            wr(chA(ch, 4), 32'(du));
            wr(chA(ch, 8), 32'(p));
            chk("R6 disabled pin equals invert", pwm_out[ch], inv);
            rd(chA(ch, 4), d); chk("R8 direct duty while off", d, du);
            rd(chA(ch, 8), d); chk("R8 direct period while off", d, p);
            wr(12'h004, 32'(1 << ch));
            chk("R6 first level from counter 0", pwm_out[ch], (du > 0 ? 0 : 1) ^ inv);
            measure(ch, p << k, hi);
            chk("R5 high clocks per period", hi, exp_high(p, du, k, inv));
            for (int o = 0; o < 4; o++)
                if (o != ch) chk("R6 other channel idle", pwm_out[o], polv[o]);
            rd(12'h00C, d); chk("R2 single channel status", d, 1 << ch);
        end

        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_bad++;
            n_chk++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule